// File: doc/BRIEF.md
# Branch-Aware Program Counter Unit

This block keeps the fetch address of a small 16-bit processor and picks the address of the next instruction whenever the core advances. On each cycle where the advance strobe is high, it looks at the instruction word that was just fetched. If that word is a conditional branch and the compare flag named by its condition field is set, the unit loads the absolute target carried in the word. In every other case it steps to the following word address.

The three compare flags (equal, greater, less) come from outside, from the most recent compare. Instruction memory, decoding of every other format and the logic that produces the flags sit outside this block. The address counts 16-bit words, so a sequential step adds one.

Top module: `fetch_addr_unit`

## Requirements
- R1: When `rst_n` is sampled low at a rising clock edge, `fetch_addr` is 0 after that edge, whatever the other inputs are.
- R2: When `step_en` is low (and `rst_n` high), `fetch_addr` keeps its value, even if the instruction is a branch whose flag is set.
- R3: A word is a conditional branch only when `instr_word[1:0]` is binary 10; a word with any other value there advances `fetch_addr` by one.
- R4: For a branch, `instr_word[3:2]` picks the flag: 00 selects `cmp_eq`, 01 selects `cmp_gt`, 10 selects `cmp_lt`; the branch is taken when the selected flag is 1 and not taken when it is 0.
- R5: A branch with `instr_word[3:2]` equal to 11 is never taken, whatever the flags are; `fetch_addr` advances by one.
- R6: A taken branch loads `instr_word[15:4]` zero-extended to 16 bits (upper four bits 0) into `fetch_addr`.
- R7: A step that takes no branch sets `fetch_addr` to its old value plus one, modulo 2^16 (0xFFFF steps to 0x0000).
- R8: The two flags that the condition field does not select have no effect on the next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance strobe: the address may change only when high |
| instr_word | input | 16 | Instruction word at the current fetch address |
| cmp_eq | input | 1 | Last compare found its operands equal |
| cmp_gt | input | 1 | Last compare found the first operand greater |
| cmp_lt | input | 1 | Last compare found the first operand less |
| fetch_addr | output | 16 | Word address of the instruction to fetch |

## Verification
The assertions take for granted that `step_en`, `instr_word` and the flags are stable around the rising edge, and that reset is held for at least one edge before the first advance, so that every `$past` of the address refers to a defined value. The stimulus drives all inputs at the falling edge and starts with reset low for several cycles. Flags are driven independently of the instruction, including patterns with all three set or where only an unselected flag is set, so that the flag choice is exercised without assuming that the flags are mutually exclusive.

// File: rtl/fau_pkg.sv
package fau_pkg;

    // Width of an instruction word.
    localparam int unsigned INSTR_W = 16;

    // Format tag value in the two low bits that marks a conditional branch.
    localparam logic [1:0] FMT_COND_BRANCH = 2'b10;

    // Bit range of the format tag, condition field and target field.
    localparam int unsigned FMT_LSB  = 0;
    localparam int unsigned COND_LSB = 2;
    localparam int unsigned TGT_LSB  = 4;
    localparam int unsigned TGT_W    = INSTR_W - TGT_LSB;

    // Encoding of the condition field.
    typedef enum logic [1:0] {
        SEL_EQ    = 2'b00,
        SEL_GT    = 2'b01,
        SEL_LT    = 2'b10,
        SEL_NEVER = 2'b11
    } cond_sel_e;

endpackage

// File: rtl/fau_take_eval.sv
// Decides whether the current word is a taken conditional branch.
// Assumes the flags are already registered outside and stable for the cycle.
module fau_take_eval
    import fau_pkg::*;
(
    input  logic [1:0] fmt_tag,
    input  logic [1:0] cond_field,
    input  logic       flag_eq,
    input  logic       flag_gt,
    input  logic       flag_lt,
    output logic       take
);

    cond_sel_e sel;
    logic      flag_hit;

    assign sel = cond_sel_e'(cond_field);

    // Pick the one flag named by the condition field.
    always_comb begin
        unique case (sel)
            SEL_EQ:    flag_hit = flag_eq;
            SEL_GT:    flag_hit = flag_gt;
            SEL_LT:    flag_hit = flag_lt;
            default:   flag_hit = 1'b0;
        endcase
    end

    // A branch is taken only for the branch format with its flag set.
    always_comb begin
        take = (fmt_tag == FMT_COND_BRANCH) && flag_hit;
    end

endmodule

// File: rtl/fau_next_sel.sv
// Forms the candidate next address: the zero-extended branch target or
// the sequential successor. Assumes ADDR_W is at least TGT_W.
module fau_next_sel #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned TGT_W  = 12
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [TGT_W-1:0]  tgt_field,
    input  logic              take,
    output logic [ADDR_W-1:0] next_addr
);

    localparam int unsigned PAD_W = ADDR_W - TGT_W;

    logic [ADDR_W-1:0] tgt_ext;
    logic [ADDR_W-1:0] seq_addr;

    // Zero-extend the target; no padding when the widths already match.
    generate
        if (PAD_W > 0) begin : g_pad
            assign tgt_ext = {{PAD_W{1'b0}}, tgt_field};
        end else begin : g_nopad
            assign tgt_ext = tgt_field;
        end
    endgenerate

    // Word-addressed successor, wrapping at the top of the address space.
    always_comb begin
        seq_addr = cur_addr + {{(ADDR_W-1){1'b0}}, 1'b1};
    end

    // Choose between the target and the successor.
    always_comb begin
        next_addr = take ? tgt_ext : seq_addr;
    end

endmodule

// File: rtl/fau_addr_reg.sv
// Holds the fetch address. Synchronous active-low reset to zero;
// loads the candidate only on cycles with the advance strobe high.
module fau_addr_reg #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] next_addr,
    output logic [ADDR_W-1:0] addr_q
);

    // Address register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= next_addr;
        end
    end

endmodule

// File: rtl/fetch_addr_unit.sv
// Program counter with conditional-branch selection. Steps by one word or
// loads a 12-bit absolute target when a branch's selected flag is set.
// Assumes the word on instr_word belongs to the address on fetch_addr.
module fetch_addr_unit
    import fau_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic [INSTR_W-1:0]  instr_word,
    input  logic                cmp_eq,
    input  logic                cmp_gt,
    input  logic                cmp_lt,
    output logic [ADDR_W-1:0]   fetch_addr
);

    logic              take;
    logic [ADDR_W-1:0] next_addr;

    fau_take_eval u_eval (
        .fmt_tag    (instr_word[FMT_LSB+1:FMT_LSB]),
        .cond_field (instr_word[COND_LSB+1:COND_LSB]),
        .flag_eq    (cmp_eq),
        .flag_gt    (cmp_gt),
        .flag_lt    (cmp_lt),
        .take       (take)
    );

    fau_next_sel #(
        .ADDR_W (ADDR_W),
        .TGT_W  (TGT_W)
    ) u_next (
        .cur_addr  (fetch_addr),
        .tgt_field (instr_word[INSTR_W-1:TGT_LSB]),
        .take      (take),
        .next_addr (next_addr)
    );

    fau_addr_reg #(
        .ADDR_W (ADDR_W)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (step_en),
        .next_addr (next_addr),
        .addr_q    (fetch_addr)
    );

endmodule

// File: rtl/fetch_addr_unit_chk.sv
// Property checker for fetch_addr_unit, attached through bind.
module fetch_addr_unit_chk
    import fau_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                step_en,
    input logic [INSTR_W-1:0]  instr_word,
    input logic                cmp_eq,
    input logic                cmp_gt,
    input logic                cmp_lt,
    input logic [ADDR_W-1:0]   fetch_addr
);

    logic rst_seen_q = 1'b0;
    logic is_br;

    assign is_br = (instr_word[1:0] == 2'b10);

    // Remember that reset was sampled low at the last edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1
    always @(negedge clk) begin
        if (rst_seen_q) begin
            reset_zero_chk: assert (fetch_addr == '0);
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(fetch_addr));

    // R3
    other_fmt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !is_br) |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

    // R4
    gt_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && is_br && instr_word[3:2] == 2'b01 && cmp_gt)
        |=> fetch_addr == ADDR_W'($past(instr_word[15:4])));

    // R4
    lt_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && is_br && instr_word[3:2] == 2'b10 && cmp_lt)
        |=> fetch_addr == ADDR_W'($past(instr_word[15:4])));

    // R6
    eq_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && is_br && instr_word[3:2] == 2'b00 && cmp_eq)
        |=> fetch_addr == ADDR_W'($past(instr_word[15:4])));

    // R5
    never_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && is_br && instr_word[3:2] == 2'b11)
        |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

    // R8
    eq_clear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && is_br && instr_word[3:2] == 2'b00 && !cmp_eq)
        |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

endmodule

bind fetch_addr_unit fetch_addr_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .instr_word (instr_word),
    .cmp_eq     (cmp_eq),
    .cmp_gt     (cmp_gt),
    .cmp_lt     (cmp_lt),
    .fetch_addr (fetch_addr)
);

// File: tb/tb_fetch_addr_unit.sv
`timescale 1ns/1ps
module tb_fetch_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [15:0] instr_word = '0;
    logic        cmp_eq = 1'b0;
    logic        cmp_gt = 1'b0;
    logic        cmp_lt = 1'b0;
    logic [15:0] fetch_addr;

    int checks = 0;
    int failures = 0;
    int model_pc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fetch_addr_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .instr_word (instr_word),
        .cmp_eq     (cmp_eq),
        .cmp_gt     (cmp_gt),
        .cmp_lt     (cmp_lt),
        .fetch_addr (fetch_addr)
    );

    // Behavioural reference: next address from the requirement text.
    function automatic int ref_next(int pc, bit rst_low, bit adv,
                                    int iw, bit eq, bit gt, bit lt);
        int c;
        bit f;
        if (rst_low) return 0;
        if (!adv) return pc;
        if ((iw & 3) == 2) begin
            c = (iw >> 2) & 3;
            f = (c == 0) ? eq : (c == 1) ? gt : (c == 2) ? lt : 1'b0;
            if (f) return (iw >> 4) & 16'h0FFF;
        end
        return (pc + 1) % 65536;
    endfunction

    // One clock: drive at the falling edge, check at the next falling edge.
    task automatic cyc(bit rl, bit adv, logic [15:0] iw,
                       bit eq, bit gt, bit lt, string req);
        rst_n = !rl; step_en = adv; instr_word = iw;
        cmp_eq = eq; cmp_gt = gt; cmp_lt = lt;
        model_pc = ref_next(model_pc, rl, adv, int'(iw), eq, gt, lt);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (int'(fetch_addr) != model_pc) begin
            failures++;
            $display("FAIL %s: fetch_addr=0x%04h expected=0x%04h",
                     req, fetch_addr, model_pc[15:0]);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cyc(1, 1, 16'h1232, 1, 1, 1, "R1");
        cyc(1, 0, 16'h0000, 0, 0, 0, "R1");
        // R7: plain steps
        cyc(0, 1, 16'h0001, 0, 0, 0, "R7");
        cyc(0, 1, 16'h0003, 1, 1, 1, "R3");
        cyc(0, 1, 16'hFFF0, 1, 1, 1, "R3");
        cyc(0, 1, 16'h5551, 1, 1, 1, "R3");
        // R2: hold even with a taken-looking branch
        cyc(0, 0, 16'h4562, 1, 0, 0, "R2");
        cyc(0, 0, 16'h0003, 0, 0, 0, "R2");
        // R4: each condition, taken
        cyc(0, 1, 16'h1232, 1, 0, 0, "R4");
        cyc(0, 1, 16'h0456, 0, 1, 0, "R4");
        cyc(0, 1, 16'h078A, 0, 0, 1, "R4");
        // R4: each condition, not taken
        cyc(0, 1, 16'h1232, 0, 0, 0, "R4");
        cyc(0, 1, 16'h0456, 0, 0, 0, "R4");
        cyc(0, 1, 16'h078A, 0, 0, 0, "R4");
        // R8: only unselected flags set
        cyc(0, 1, 16'h3332, 0, 1, 1, "R8");
        cyc(0, 1, 16'h3336, 1, 0, 1, "R8");
        cyc(0, 1, 16'h333A, 1, 1, 0, "R8");
        // R5: condition 11 never taken
        cyc(0, 1, 16'hABCE, 1, 1, 1, "R5");
        cyc(0, 1, 16'h000E, 1, 1, 1, "R5");
        // R6: largest target, zero-extended to 0x0FFF
        cyc(0, 1, 16'hFFF2, 1, 0, 0, "R6");
        cyc(0, 1, 16'h0002, 1, 0, 0, "R6");
        // R1: reset in mid-run with a taken branch presented
        cyc(0, 1, 16'h0402, 1, 0, 0, "R6");
        cyc(1, 1, 16'h0402, 1, 0, 0, "R1");
        // R7: walk the full space to see 0xFFFF wrap to 0x0000
        for (int i = 0; i < 65537; i++) cyc(0, 1, 16'h0001, 0, 0, 0, "R7");
        // Mixed random traffic against the reference
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] w = 16'($urandom);
            if (i % 3 == 0) w[1:0] = 2'b10;
            cyc(($urandom % 97) == 0, ($urandom % 4) != 0, w,
                1'($urandom), 1'($urandom), 1'($urandom), "R4");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: cycles=150000 expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule